// File: doc/BRIEF.md
# ADC Analog Watchdog Threshold Monitor

This block watches the stream of finished analog conversions and reports results that fall outside a programmed window. It holds a small bank of threshold sets. Each set has a lower bound, an upper bound, a bound-channel field and an enable bit. When a conversion-done strobe arrives, every enabled set whose bound channel matches the strobe's channel number compares the result word against its window. A set ignores results from any other channel. To watch a different channel, software rewrites that set's channel field.

Each set owns two sticky violation flags, one for the low side and one for the high side. A flag stays up until software writes a one to its clear bit. Each flag also has a mask bit that decides whether it drives an interrupt line. The low comparison is always resolved first. A result under the lower bound raises only the low flag. Only a result that passes that test can raise the high flag. This keeps the two flags mutually exclusive per conversion, even when the upper bound is programmed below the lower bound.

Each set's flag pair is held by a four-state machine:
- States: `WD_CLEAR`, `WD_LOW`, `WD_HIGH`, `WD_BOTH`.
- A state moves up (`WD_CLEAR`→`WD_LOW`, `WD_CLEAR`→`WD_HIGH`, `WD_LOW`→`WD_BOTH`, `WD_HIGH`→`WD_BOTH`) on a low or high hit.
- A state moves down (`WD_BOTH`→`WD_HIGH`, `WD_BOTH`→`WD_LOW`, `WD_LOW`→`WD_CLEAR`, `WD_HIGH`→`WD_CLEAR`, `WD_BOTH`→`WD_CLEAR`) on a clear of the matching flag.
- A state stays put when neither a hit nor a clear arrives.
- A hit and a clear for the same flag on the same edge leave that flag set.

Top module: `awd_monitor`

## Requirements
- R1: After reset all low and high flags, all interrupt lines and `irq_any` are 0, and every set is disabled.
- R2: A set evaluates a conversion only when it is enabled and `conv_chan` equals its bound channel. Any other conversion leaves its flags unchanged.
- R3: A result strictly below a set's lower bound raises that set's low flag. A result equal to the lower bound raises no low flag.
- R4: A result that is not below the lower bound and is strictly above the upper bound raises the high flag. A result equal to the upper bound raises no high flag.
- R5: When the upper bound is below the lower bound, a result under the lower bound raises only the low flag, and a result at or above the lower bound raises only the high flag. One conversion never raises both flags of a set.
- R6: Flags change only at the first rising edge at which `conv_done` is sampled high (one register of latency). Without a strobe, no flag rises.
- R7: Flags are sticky. Writing 1 to bit i of `clr_lo`/`clr_hi` clears the matching flag of set i. If a new violation arrives on the same edge as the clear, the flag stays set.
- R8: `irq_lo[i]` is `flag_lo[i] & mask_lo[i]`, `irq_hi[i]` is `flag_hi[i] & mask_hi[i]`, and `irq_any` is the OR of all interrupt lines. Masks do not affect the flags.
- R9: A pulse on `cfg_we` writes the lower bound, upper bound, channel and enable of set `cfg_idx` at that edge. Conversions sampled on later edges use the new values, and the write leaves existing flags untouched.
- R10: After a set's channel field is rewritten, the set stops watching its old channel and watches only the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_chan | input | CH_W | Channel number of the finished conversion |
| conv_data | input | RES_W | Conversion result |
| cfg_we | input | 1 | Write strobe for one threshold set |
| cfg_idx | input | IDX_W | Index of the set being written |
| cfg_lo | input | RES_W | New lower bound |
| cfg_hi | input | RES_W | New upper bound |
| cfg_chan | input | CH_W | New bound channel |
| cfg_en | input | 1 | New enable bit |
| clr_lo | input | N_SETS | Write-one-to-clear for the low flags |
| clr_hi | input | N_SETS | Write-one-to-clear for the high flags |
| mask_lo | input | N_SETS | Interrupt enable for the low flags |
| mask_hi | input | N_SETS | Interrupt enable for the high flags |
| flag_lo | output | N_SETS | Sticky low-violation flags |
| flag_hi | output | N_SETS | Sticky high-violation flags |
| irq_lo | output | N_SETS | Masked low interrupt lines |
| irq_hi | output | N_SETS | Masked high interrupt lines |
| irq_any | output | 1 | OR of all interrupt lines |

## Verification
The checker watches four properties on every cycle:
- No flag rises without a strobe on the previous edge.
- A flag never drops unless its clear bit was written.
- One conversion never raises both flags of the same set.
- `irq_any` is never high without some flag behind it.

The bench's scenarios are the only way to show the comparison itself:
- exact bound equality;
- the inverted-window resolution;
- channel binding and rebinding;
- the disabled set;
- a clear that collides with a new hit;
- mask gating.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // Flag-pair state of one threshold set: bit0 = low flag, bit1 = high flag
    typedef enum logic [1:0] {
        WD_CLEAR = 2'b00,
        WD_LOW   = 2'b01,
        WD_HIGH  = 2'b10,
        WD_BOTH  = 2'b11
    } wd_state_e;

    function automatic wd_state_e wd_pack(input logic lo, input logic hi);
        return wd_state_e'({hi, lo});
    endfunction

endpackage

// File: rtl/awd_cfg_bank.sv
module awd_cfg_bank #(
    parameter int N_SETS = 4,
    parameter int RES_W  = 10,
    parameter int CH_W   = 5,
    parameter int IDX_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [RES_W-1:0]              cfg_lo,
    input  logic [RES_W-1:0]              cfg_hi,
    input  logic [CH_W-1:0]               cfg_chan,
    input  logic                          cfg_en,
    output logic [N_SETS-1:0][RES_W-1:0]  lo_thr,
    output logic [N_SETS-1:0][RES_W-1:0]  hi_thr,
    output logic [N_SETS-1:0][CH_W-1:0]   sel_chan,
    output logic [N_SETS-1:0]             set_en
);

    for (genvar g = 0; g < N_SETS; g++) begin : g_set
        // Whole set is written in one cycle so rebinding is atomic
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_thr[g]   <= '0;
                hi_thr[g]   <= '1;
                sel_chan[g] <= '0;
                set_en[g]   <= 1'b0;
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                lo_thr[g]   <= cfg_lo;
                hi_thr[g]   <= cfg_hi;
                sel_chan[g] <= cfg_chan;
                set_en[g]   <= cfg_en;
            end
        end
    end

endmodule

// File: rtl/awd_cmp.sv
module awd_cmp #(
    parameter int RES_W = 10,
    parameter int CH_W  = 5
) (
    input  logic             conv_done,
    input  logic [CH_W-1:0]  conv_chan,
    input  logic [RES_W-1:0] conv_data,
    input  logic [RES_W-1:0] lo_thr,
    input  logic [RES_W-1:0] hi_thr,
    input  logic [CH_W-1:0]  sel_chan,
    input  logic             set_en,
    output logic             hit_lo,
    output logic             hit_hi
);

    logic match;
    logic below;
    logic above;

    always_comb begin
        match  = conv_done && set_en && (conv_chan == sel_chan);
        below  = conv_data < lo_thr;
        above  = conv_data > hi_thr;
        // Low side resolved first: a low hit suppresses the high test
        hit_lo = match && below;
        hit_hi = match && !below && above;
    end

endmodule

// File: rtl/awd_flag_fsm.sv
module awd_flag_fsm
    import awd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_lo,
    input  logic hit_hi,
    input  logic clr_lo,
    input  logic clr_hi,
    output logic flag_lo,
    output logic flag_hi
);

    wd_state_e state_q;
    wd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a hit on the same edge as a clear keeps the flag
    always_comb begin
        unique case (state_q)
            WD_CLEAR: state_d = wd_pack(hit_lo, hit_hi);
            WD_LOW:   state_d = wd_pack(!clr_lo || hit_lo, hit_hi);
            WD_HIGH:  state_d = wd_pack(hit_lo, !clr_hi || hit_hi);
            WD_BOTH:  state_d = wd_pack(!clr_lo || hit_lo, !clr_hi || hit_hi);
            default:  state_d = WD_CLEAR;
        endcase
    end

    always_comb begin
        flag_lo = (state_q == WD_LOW)  || (state_q == WD_BOTH);
        flag_hi = (state_q == WD_HIGH) || (state_q == WD_BOTH);
    end

endmodule

// File: rtl/awd_monitor.sv
module awd_monitor #(
    parameter int N_SETS = 4,
    parameter int RES_W  = 10,
    parameter int CH_W   = 5,
    localparam int IDX_W = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [RES_W-1:0]  cfg_lo,
    input  logic [RES_W-1:0]  cfg_hi,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_en,
    input  logic [N_SETS-1:0] clr_lo,
    input  logic [N_SETS-1:0] clr_hi,
    input  logic [N_SETS-1:0] mask_lo,
    input  logic [N_SETS-1:0] mask_hi,
    output logic [N_SETS-1:0] flag_lo,
    output logic [N_SETS-1:0] flag_hi,
    output logic [N_SETS-1:0] irq_lo,
    output logic [N_SETS-1:0] irq_hi,
    output logic              irq_any
);

    logic [N_SETS-1:0][RES_W-1:0] lo_thr;
    logic [N_SETS-1:0][RES_W-1:0] hi_thr;
    logic [N_SETS-1:0][CH_W-1:0]  sel_chan;
    logic [N_SETS-1:0]            set_en;
    logic [N_SETS-1:0]            hit_lo;
    logic [N_SETS-1:0]            hit_hi;

    awd_cfg_bank #(
        .N_SETS (N_SETS),
        .RES_W  (RES_W),
        .CH_W   (CH_W),
        .IDX_W  (IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_lo   (cfg_lo),
        .cfg_hi   (cfg_hi),
        .cfg_chan (cfg_chan),
        .cfg_en   (cfg_en),
        .lo_thr   (lo_thr),
        .hi_thr   (hi_thr),
        .sel_chan (sel_chan),
        .set_en   (set_en)
    );

    for (genvar s = 0; s < N_SETS; s++) begin : g_wd
        awd_cmp #(
            .RES_W (RES_W),
            .CH_W  (CH_W)
        ) u_cmp (
            .conv_done (conv_done),
            .conv_chan (conv_chan),
            .conv_data (conv_data),
            .lo_thr    (lo_thr[s]),
            .hi_thr    (hi_thr[s]),
            .sel_chan  (sel_chan[s]),
            .set_en    (set_en[s]),
            .hit_lo    (hit_lo[s]),
            .hit_hi    (hit_hi[s])
        );

        awd_flag_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_lo  (hit_lo[s]),
            .hit_hi  (hit_hi[s]),
            .clr_lo  (clr_lo[s]),
            .clr_hi  (clr_hi[s]),
            .flag_lo (flag_lo[s]),
            .flag_hi (flag_hi[s])
        );
    end

    always_comb begin
        irq_lo  = flag_lo & mask_lo;
        irq_hi  = flag_hi & mask_hi;
        irq_any = |{irq_lo, irq_hi};
    end

endmodule

// File: rtl/awd_monitor_chk.sv
module awd_monitor_chk #(
    parameter int N_SETS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [N_SETS-1:0] clr_lo,
    input logic [N_SETS-1:0] clr_hi,
    input logic [N_SETS-1:0] flag_lo,
    input logic [N_SETS-1:0] flag_hi,
    input logic              irq_any
);

    // R6: a rising flag needs a strobe on the previous edge
    assert_rise_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((flag_lo & ~$past(flag_lo)) | (flag_hi & ~$past(flag_hi))) != '0) |-> $past(conv_done));

    // R7: low flags only drop when cleared
    assert_sticky_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_lo) & ~$past(clr_lo) & ~flag_lo) == '0));

    // R7: high flags only drop when cleared
    assert_sticky_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_hi) & ~$past(clr_hi) & ~flag_hi) == '0));

    // R5: one conversion never raises both flags of a set
    assert_single_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_lo & ~$past(flag_lo) & flag_hi & ~$past(flag_hi)) == '0));

    // R8: the summary interrupt always has a flag behind it
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> ((flag_lo | flag_hi) != '0));

endmodule

bind awd_monitor awd_monitor_chk #(.N_SETS(N_SETS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .clr_lo    (clr_lo),
    .clr_hi    (clr_hi),
    .flag_lo   (flag_lo),
    .flag_hi   (flag_hi),
    .irq_any   (irq_any)
);

// File: tb/awd_monitor_tb_top.sv
module awd_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int RW = 10;
    localparam int CW = 5;
    localparam int NV = 11;

    // {chan[22:18], data[17:8], exp_lo[7:4], exp_hi[3:0]}
    // set0 ch3 100..900 on, set1 ch3 lo500 hi200 on, set2 ch7 300..400 on, set3 ch3 off
    localparam logic [22:0] VECS [NV] = '{
        {5'd3, 10'd50,   4'b0011, 4'b0000},
        {5'd3, 10'd950,  4'b0000, 4'b0011},
        {5'd3, 10'd100,  4'b0010, 4'b0000},
        {5'd3, 10'd900,  4'b0000, 4'b0010},
        {5'd3, 10'd500,  4'b0000, 4'b0010},
        {5'd7, 10'd250,  4'b0100, 4'b0000},
        {5'd7, 10'd401,  4'b0000, 4'b0100},
        {5'd7, 10'd300,  4'b0000, 4'b0000},
        {5'd5, 10'd0,    4'b0000, 4'b0000},
        {5'd3, 10'd300,  4'b0010, 4'b0000},
        {5'd7, 10'd1023, 4'b0000, 4'b0100}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_done = 1'b0;
    logic [CW-1:0] conv_chan = '0;
    logic [RW-1:0] conv_data = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic [RW-1:0] cfg_lo = '0;
    logic [RW-1:0] cfg_hi = '0;
    logic [CW-1:0] cfg_chan = '0;
    logic          cfg_en = 1'b0;
    logic [NS-1:0] clr_lo = '0;
    logic [NS-1:0] clr_hi = '0;
    logic [NS-1:0] mask_lo = '0;
    logic [NS-1:0] mask_hi = '0;
    logic [NS-1:0] flag_lo;
    logic [NS-1:0] flag_hi;
    logic [NS-1:0] irq_lo;
    logic [NS-1:0] irq_hi;
    logic          irq_any;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    awd_monitor #(.N_SETS(NS), .RES_W(RW), .CH_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .conv_done(conv_done), .conv_chan(conv_chan), .conv_data(conv_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_chan(cfg_chan), .cfg_en(cfg_en),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .mask_lo(mask_lo), .mask_hi(mask_hi),
        .flag_lo(flag_lo), .flag_hi(flag_hi), .irq_lo(irq_lo), .irq_hi(irq_hi),
        .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] idx, input int lo, input int hi,
                       input int ch, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx;
        cfg_lo = RW'(lo); cfg_hi = RW'(hi); cfg_chan = CW'(ch); cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present a conversion for one edge; on return the flags reflect it
    task automatic conv(input int ch, input int data);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = CW'(ch); conv_data = RW'(data);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic clear(input logic [NS-1:0] lo, input logic [NS-1:0] hi);
        @(negedge clk);
        clr_lo = lo; clr_hi = hi;
        @(negedge clk);
        clr_lo = '0; clr_hi = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag_lo after reset", 32'(flag_lo), 32'h0);
        chk("R1 flag_hi after reset", 32'(flag_hi), 32'h0);
        chk("R1 irq_any after reset", 32'(irq_any), 32'h0);
        // R1: sets start disabled, so even a far-out result on ch0 raises nothing
        conv(0, 1023);
        chk("R1 disabled sets ignore conversion", 32'({flag_lo, flag_hi}), 32'h0);

        cfg(2'd0, 100, 900, 3, 1'b1);
        cfg(2'd1, 500, 200, 3, 1'b1);
        cfg(2'd2, 300, 400, 7, 1'b1);
        cfg(2'd3, 100, 900, 3, 1'b0);

        // Vector walk: R2 binding/enable, R3 low, R4 high, R5 inverted window
        for (int k = 0; k < NV; k++) begin
            conv(int'(VECS[k][22:18]), int'(VECS[k][17:8]));
            chk($sformatf("R3/R2 vec%0d flag_lo", k), 32'(flag_lo), 32'(VECS[k][7:4]));
            chk($sformatf("R4/R5 vec%0d flag_hi", k), 32'(flag_hi), 32'(VECS[k][3:0]));
            clear('1, '1);
        end

        // R6: no flag before the edge, flag right after
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 5'd3; conv_data = 10'd10;
        #1;
        chk("R6 no flag before edge", 32'(flag_lo), 32'h0);
        @(negedge clk);
        conv_done = 1'b0;
        chk("R6 flag after one edge", 32'(flag_lo), 32'h3);
        // R6: data changes without a strobe do nothing
        clear('1, '1);
        @(negedge clk);
        conv_chan = 5'd3; conv_data = 10'd0;
        repeat (2) @(negedge clk);
        chk("R6 no strobe no flag", 32'({flag_lo, flag_hi}), 32'h0);

        // R9: reconfig keeps flag; R10: rebinding set0 to ch7
        conv(3, 50);
        cfg(2'd0, 100, 900, 7, 1'b1);
        chk("R9 cfg write keeps flag", 32'(flag_lo[0]), 32'h1);
        clear('1, '1);
        conv(3, 50);
        chk("R10 old channel ignored", 32'(flag_lo[0]), 32'h0);
        clear('1, '1);
        conv(7, 50);
        chk("R10 new channel watched", 32'(flag_lo), 32'h5);

        // R7: sticky through an in-range result
        conv(7, 350);
        chk("R7 sticky flag_lo", 32'(flag_lo), 32'h5);
        conv(7, 500);
        chk("R7 high added", 32'(flag_hi), 32'h4);
        clear(4'b0100, 4'b0000);
        chk("R7 partial clear lo", 32'(flag_lo), 32'h1);
        chk("R7 partial clear keeps hi", 32'(flag_hi), 32'h4);
        // R7: hit and clear on the same edge -> flag stays
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 5'd7; conv_data = 10'd50; clr_lo = 4'b0001;
        @(negedge clk);
        conv_done = 1'b0; clr_lo = '0;
        chk("R7 set wins over clear", 32'(flag_lo), 32'h5);

        // R8: mask gating
        mask_lo = '0; mask_hi = '0;
        #1;
        chk("R8 masked irq_any", 32'(irq_any), 32'h0);
        mask_hi = 4'b0100;
        #1;
        chk("R8 irq_hi unmasked", 32'(irq_hi), 32'h4);
        chk("R8 irq_lo still masked", 32'(irq_lo), 32'h0);
        chk("R8 irq_any", 32'(irq_any), 32'h1);
        chk("R8 mask leaves flags", 32'(flag_lo), 32'h5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule